// File: doc/BRIEF.md
# Serial LED Status Transmitter

This block reports the state of several storage ports to an external LED controller over three wires: a serial clock, a load strobe and a serial data line. A host request carries a port number and a 32-bit status word. On acceptance, the block decodes three indicators from the status word: activity, locate and fault. It writes them into a stored pattern at a slot chosen by a programmable port-to-slot table. It then sends the whole pattern to the controller.

Each transfer has four parts. It opens with a programmable number of bare clock cycles. One cycle follows with the load strobe high. Then come three data bits per port, least significant bit first. A programmable number of bare trailing cycles closes it. The serial clock is derived from the system clock by a tick divider. Each serial cycle holds the clock high for `TICK_DIV` system cycles and then low for `TICK_DIV` system cycles. While a transfer runs, `busy` is high and `req_ready` is low, so a new request waits.

Top module: `led_status_tx`

## Requirements
- R1: After reset and whenever no transfer runs, `led_clk`, `led_load` and `led_data` are all high, `busy` is low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `busy` is high, `req_ready` stays low, and a request held during that time changes neither the transfer nor the stored pattern.
- R3: The slot field is `req_status[15:8]`. An accepted request whose slot field is at or above `MAX_SLOTS` starts no transfer and leaves the stored pattern unchanged.
- R4: The activity indicator is 1 when `req_status[21]` or `req_status[20]` is 1. The locate indicator equals `req_status[19]`, and the fault indicator equals `req_status[22]`. No other status bit affects the pattern.
- R5: For port p, the slot s is `slot_map[p*PORT_W +: PORT_W]`. Activity is stored at pattern bit 3*s, locate at 3*s+1 and fault at 3*s+2. All other pattern bits keep their values.
- R6: A transfer is `pre_clks` + 1 + 3*`NUM_PORTS` + `post_clks` serial cycles long, counted as rising edges of `led_clk` while `busy` is high. Pre-cycles have load low and data high. Exactly one cycle then has load high and data high. The data cycles follow, with load low and pattern bits 0 upward. Post-cycles have load low and data high.
- R7: An accepted transfer first drives `led_clk` low for `TICK_DIV` system cycles. Each serial cycle is then high for `TICK_DIV` system cycles and low for `TICK_DIV` system cycles.
- R8: During a transfer, `led_load` and `led_data` change only while `led_clk` is low, so they are stable before each rising edge.
- R9: `busy` rises on the accepting edge. It falls at the end of the last low phase, on the same edge where all three serial outputs return high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | PORT_W | Logical port number of the request |
| req_status | input | 32 | Status word (indicators and slot field) |
| slot_map | input | NUM_PORTS*PORT_W | Pattern slot for each logical port |
| pre_clks | input | CFG_W | Bare clock cycles before the load cycle |
| post_clks | input | CFG_W | Bare clock cycles after the data bits |
| led_clk | output | 1 | Serial clock to the LED controller |
| led_load | output | 1 | Load strobe |
| led_data | output | 1 | Serial data |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with `NUM_PORTS`=4, `CFG_W`=2 and `TICK_DIV`=2. A whole frame is then at most 19 serial cycles, and every pair of pre and post counts from 0 to 3 can be swept in full. With two-cycle phases, each high and low width can be measured exactly. All sixteen combinations of the four indicator status bits are applied across the sweep. The 2-bit slot table allows identity, reversed and rotated mappings. The 8-bit slot field reaches both sides of the rejection bound with a few values.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_HIGH,
    SQ_LOW,
    SQ_TAIL
  } seq_state_e;

  localparam int unsigned IND_PER_PORT = 3;

  // {fault, locate, activity}
  function automatic logic [2:0] decode_status(input logic [31:0] s);
    return {s[22], s[19], (s[21] | s[20])};
  endfunction

  function automatic logic [7:0] slot_field(input logic [31:0] s);
    return s[15:8];
  endfunction

  function automatic int unsigned slot_base(input int unsigned slot);
    return slot * IND_PER_PORT;
  endfunction

endpackage

// File: rtl/led_pattern_store.sv
module led_pattern_store
  import led_tx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd_en,
  input  logic [PORT_W-1:0]             upd_port,
  input  logic [2:0]                    upd_ind,
  input  logic [NUM_PORTS*PORT_W-1:0]   slot_map,
  output logic [IND_PER_PORT*NUM_PORTS-1:0] pattern
);
  localparam int unsigned NBITS = IND_PER_PORT * NUM_PORTS;

  logic [PORT_W-1:0] slot_sel;
  int unsigned       base;

  always_comb begin
    slot_sel = slot_map[upd_port*PORT_W +: PORT_W];
    base     = slot_base(int'(slot_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pattern <= '0;
    else if (upd_en) pattern[base +: IND_PER_PORT] <= upd_ind;
  end

  // R5: a write touches only its own three-bit slot
  a_r5_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> ((pattern ^ $past(pattern)) & ~(NBITS'(7) << $past(base))) == '0);

endmodule

// File: rtl/led_bit_sequencer.sv
module led_bit_sequencer
  import led_tx_pkg::*;
#(
  parameter int unsigned NBITS    = 12,
  parameter int unsigned CFG_W    = 4,
  parameter int unsigned TICK_DIV = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] pre_cfg,
  input  logic [CFG_W-1:0] post_cfg,
  input  logic [NBITS-1:0] pattern,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdata_o,
  output logic             busy_o
);
  localparam int unsigned IDX_W  = $clog2(2 * (2 ** CFG_W) + NBITS + 1);
  localparam int unsigned BIT_W  = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int unsigned TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned HOLD_W = $clog2(TICK_DIV + 2) + 1;

  seq_state_e        st;
  logic [TICK_W-1:0] tick;
  logic [IDX_W-1:0]  idx, pre_q, last_q;
  logic              tick_done;
  logic [IDX_W-1:0]  nidx, doff;
  logic              in_data, nld, ndt;

  always_comb begin
    tick_done = (tick == TICK_W'(TICK_DIV - 1));
    nidx      = idx + IDX_W'(1);
    doff      = nidx - pre_q - IDX_W'(1);
    in_data   = (nidx > pre_q) && (doff < IDX_W'(NBITS));
    nld       = (nidx == pre_q);
    ndt       = in_data ? pattern[doff[BIT_W-1:0]] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; tick <= '0; idx <= '0; pre_q <= '0; last_q <= '0;
      sclk_o <= 1'b1; sload_o <= 1'b1; sdata_o <= 1'b1;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st      <= SQ_LEAD;
          tick    <= '0;
          idx     <= '0;
          pre_q   <= IDX_W'(pre_cfg);
          last_q  <= IDX_W'(pre_cfg) + IDX_W'(NBITS) + IDX_W'(post_cfg);
          sclk_o  <= 1'b0;
          sload_o <= (pre_cfg == '0);
          sdata_o <= 1'b1;
        end
        SQ_LEAD, SQ_LOW: begin
          if (tick_done) begin
            st <= SQ_HIGH; sclk_o <= 1'b1; tick <= '0;
          end else tick <= tick + TICK_W'(1);
        end
        SQ_HIGH: begin
          if (tick_done) begin
            sclk_o <= 1'b0;
            tick   <= '0;
            if (idx == last_q) st <= SQ_TAIL;
            else begin
              st <= SQ_LOW; idx <= nidx; sload_o <= nld; sdata_o <= ndt;
            end
          end else tick <= tick + TICK_W'(1);
        end
        SQ_TAIL: begin
          if (tick_done) begin
            st <= SQ_IDLE; sclk_o <= 1'b1; sload_o <= 1'b1; sdata_o <= 1'b1;
          end else tick <= tick + TICK_W'(1);
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st != SQ_IDLE);

  // Observation wires for the assertions
  logic              hold_val;
  logic [HOLD_W-1:0] hold_cnt;
  logic [1:0]        load_seen;
  logic              sclk_rise;

  assign sclk_rise = sclk_o && !hold_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_val <= 1'b1; hold_cnt <= '0; load_seen <= '0;
    end else begin
      hold_val <= sclk_o;
      if (sclk_o != hold_val) hold_cnt <= HOLD_W'(1);
      else if (hold_cnt != '1) hold_cnt <= hold_cnt + HOLD_W'(1);
      if (!busy_o) load_seen <= '0;
      else if (sclk_rise && sload_o && load_seen != 2'd3) load_seen <= load_seen + 2'd1;
    end
  end

  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o && sload_o && sdata_o));

  a_r8_setup_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) &&
     (sload_o != $past(sload_o) || sdata_o != $past(sdata_o))) |-> !sclk_o);

  a_r7_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && sclk_o != hold_val) |-> hold_cnt == HOLD_W'(TICK_DIV));

  a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> load_seen <= 2'd1);

endmodule

// File: rtl/led_status_tx.sv
module led_status_tx
  import led_tx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned MAX_SLOTS = 8,
  parameter int unsigned CFG_W     = 4,
  parameter int unsigned TICK_DIV  = 5000,
  parameter int unsigned PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PORT_W-1:0]           req_port,
  input  logic [31:0]                 req_status,
  input  logic [NUM_PORTS*PORT_W-1:0] slot_map,
  input  logic [CFG_W-1:0]            pre_clks,
  input  logic [CFG_W-1:0]            post_clks,
  output logic                        led_clk,
  output logic                        led_load,
  output logic                        led_data,
  output logic                        busy
);
  localparam int unsigned NBITS = IND_PER_PORT * NUM_PORTS;

  logic             accept, slot_ok, start;
  logic [2:0]       ind;
  logic [NBITS-1:0] pattern;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign slot_ok   = (32'(slot_field(req_status)) < MAX_SLOTS);
  assign start     = accept && slot_ok;
  assign ind       = decode_status(req_status);

  led_pattern_store #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (start),
    .upd_port (req_port),
    .upd_ind  (ind),
    .slot_map (slot_map),
    .pattern  (pattern)
  );

  led_bit_sequencer #(.NBITS(NBITS), .CFG_W(CFG_W), .TICK_DIV(TICK_DIV)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pre_cfg  (pre_clks),
    .post_cfg (post_clks),
    .pattern  (pattern),
    .sclk_o   (led_clk),
    .sload_o  (led_load),
    .sdata_o  (led_data),
    .busy_o   (busy)
  );

  a_r3_reject_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && 32'(req_status[15:8]) >= MAX_SLOTS) |=> !busy);

  a_r3_reject_keeps_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && 32'(req_status[15:8]) >= MAX_SLOTS) |=> $stable(pattern));

  a_r2_held_request_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(pattern));

  a_r9_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && slot_ok) |=> (busy && !led_clk));

endmodule

// File: tb/led_status_tx_tb.sv
module led_status_tx_tb;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int CW = 2;
  localparam int TICK = 2;
  localparam int NB = 3 * NP;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [PW-1:0] req_port = '0;
  logic [31:0] req_status = '0;
  logic [NP*PW-1:0] slot_map = '0;
  logic [CW-1:0] pre_clks = '0, post_clks = '0;
  logic led_clk, led_load, led_data, busy;

  int checks = 0, fails = 0, cyc = 0;
  logic [NB-1:0] exp_pat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_status_tx #(.NUM_PORTS(NP), .MAX_SLOTS(8), .CFG_W(CW), .TICK_DIV(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_status(req_status), .slot_map(slot_map),
    .pre_clks(pre_clks), .post_clks(post_clks),
    .led_clk(led_clk), .led_load(led_load), .led_data(led_data), .busy(busy));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] map_of(input int p);
    return slot_map[p*PW +: PW];
  endfunction

  task automatic run_xfer(input int port, input logic [31:0] st, input int pre,
                          input int post, input bit stall);
    bit rec_ld[32]; bit rec_dt[32];
    int n = 0, run = 1, bad = 0, total;
    bit cur, pld, pdt, wid_ok = 1, set_ok = 1, rdy_ok = 1;
    int s;
    @(negedge clk);
    req_port = PW'(port); req_status = st;
    pre_clks = CW'(pre); post_clks = CW'(post); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (st[15:8] >= 8) begin
      // R3: rejected, no transfer, lines stay idle
      chk(!busy && req_ready && led_clk && led_load && led_data, "R3 reject",
          {busy, led_clk, led_load, led_data}, 4'b0111);
      return;
    end
    // model update (R4, R5)
    s = int'(map_of(port));
    exp_pat[3*s]   = st[21] | st[20];
    exp_pat[3*s+1] = st[19];
    exp_pat[3*s+2] = st[22];
    chk(busy && !led_clk, "R9 busy on accept", {busy, led_clk}, 2'b10);
    if (stall) begin
      req_port = PW'(port ^ 1); req_status = 32'h0078_0100; req_valid = 1;
    end
    cur = led_clk; pld = led_load; pdt = led_data;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
      if (req_ready) rdy_ok = 0;
      if (led_clk && (led_load != pld || led_data != pdt)) set_ok = 0;
      if (led_clk == cur) run++;
      else begin
        if (run != TICK) wid_ok = 0;
        if (led_clk && n < 32) begin rec_ld[n] = led_load; rec_dt[n] = led_data; n++; end
        cur = led_clk; run = 1;
      end
      pld = led_load; pdt = led_data;
    end
    req_valid = 0;
    if (cur != 0 || run != TICK) wid_ok = 0;
    total = pre + 1 + NB + post;
    chk(n == total, "R6 cycle count", n, total);
    chk(wid_ok, "R7 phase widths", run, TICK);
    chk(set_ok, "R8 setup in low phase", 0, 1);
    chk(rdy_ok, "R2 ready low while busy", 1, 0);
    chk(led_clk && led_load && led_data && req_ready,
        "R9/R1 idle after frame", {led_clk, led_load, led_data, req_ready}, 4'hF);
    for (int i = 0; i < total && i < n; i++) begin
      bit el, ed;
      el = (i == pre);
      ed = (i > pre && i <= pre + NB) ? exp_pat[i-pre-1] : 1'b1;
      if (rec_ld[i] != el || rec_dt[i] != ed) begin
        if (bad == 0)
          $display("FAIL R4/R5/R6 frame bit %0d: act=%0d%0d exp=%0d%0d",
                   i, rec_ld[i], rec_dt[i], el, ed);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    slot_map = {2'd3, 2'd2, 2'd1, 2'd0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(led_clk && led_load && led_data && !busy && req_ready, "R1 reset",
        {led_clk, led_load, led_data, busy, req_ready}, 5'b11101);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(led_clk && led_load && led_data && !busy, "R1 after reset",
        {led_clk, led_load, led_data, busy}, 4'b1110);
    // R6/R7/R4 sweep: every pre/post pair, all indicator combos
    for (int i = 0; i < 16; i++) begin
      logic [31:0] st;
      st = 32'hA500_005A;
      st[19] = i[0]; st[20] = i[1]; st[21] = i[2]; st[22] = i[3];
      st[15:8] = 8'(i % 8);
      run_xfer(i % NP, st, i / 4, i % 4, 0);
    end
    // R5: reversed mapping
    slot_map = {2'd0, 2'd1, 2'd2, 2'd3};
    for (int p = 0; p < NP; p++)
      run_xfer(p, (p[0] ? 32'h0048_0000 : 32'h0010_0000) | 32'(p << 8), 1, 2, 0);
    // R3: slot field at and above bound, then check pattern unchanged
    run_xfer(2, 32'h0078_0800, 0, 0, 0);
    run_xfer(1, 32'h0078_FF00, 0, 0, 0);
    run_xfer(0, 32'h0000_0700, 0, 0, 0);
    // R2: held request during a transfer has no effect
    slot_map = {2'd2, 2'd1, 2'd0, 2'd3};
    run_xfer(3, 32'h0020_0000, 2, 1, 1);
    run_xfer(0, 32'h0040_0000, 3, 3, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule